// File: doc/BRIEF.md
# Framed Serial Link Transmitter

This block turns a stream of parallel words into a single serial line for a point-to-point link. On each rising edge of the word clock it captures one `DATA_W`-bit word. It then sends that word as a frame of `DATA_W + 2` bits, one bit per bit-clock cycle. The bit clock runs at `DATA_W + 2` times the word rate and is phase-related to the word clock. With the default width this means ten payload bits inside every twelve line bits. Each frame begins with a marker bit of 1, carries the payload least significant bit first, and ends with a marker bit of 0. The receiver can therefore find a 1-to-0 edge at the same place in every frame.

Two request inputs can ask the transmitter to send a training pattern. Once either request has been high on more than `HOLD_CYCLES` consecutive word-clock edges, every frame is replaced by half a frame of ones followed by half a frame of zeros. The pattern keeps repeating until both requests are low on a word-clock edge. From the following frame boundary on, data frames resume. If the requests are never raised, only data frames are sent, and the receiver has to lock onto the data itself. Transmission also needs both a power-up input and a drive-enable input to be high. A frame started while either one is low goes out as a quiet line: the bit is 0 and valid is 0.

Top module: `link_frame_tx`

## Requirements
- R1: While `rst_n` is low, `tx_bit` and `tx_valid` are both 0.
- R2: A data frame is sent in time order as a 1, then `tx_word` bits 0 through 9, then a 0. That is twelve bit-clock cycles, with `tx_bit` registered on the bit clock.
- R3: The word captured at a word-clock rising edge goes out in the frame that starts on the next bit-clock rising edge. Frames follow one another with no gap.
- R4: If `sync_req_a` or `sync_req_b` is high on 7 or more consecutive word-clock rising edges, the frame started at each such edge is the training pattern. The pattern is six 1 bits followed by six 0 bits in time order.
- R5: If a request is high on exactly 6 consecutive word-clock edges and both requests are then low, no training frame is sent. The count of consecutive edges restarts whenever both requests are low.
- R6: At the first word-clock edge with both requests low, the frame that starts is a data frame again.
- R7: `tx_valid` is 1 for a frame only if `pwr_up` and `drive_en` are both high at the bit-clock edge where that frame starts. Otherwise the whole frame is quiet.
- R8: `tx_bit` is 0 whenever `tx_valid` is 0.
- R9: `tx_valid` does not change inside a frame. It changes only at a frame start, or when no word-clock edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, 12 times the word rate |
| word_clk | input | 1 | Parallel word clock, phase-related to bit_clk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| tx_word | input | 10 | Parallel payload word |
| sync_req_a | input | 1 | Training-pattern request, first input |
| sync_req_b | input | 1 | Training-pattern request, second input |
| pwr_up | input | 1 | High for normal operation, low for power-down |
| drive_en | input | 1 | High to drive the line |
| tx_bit | output | 1 | Serial line bit |
| tx_valid | output | 1 | High while a driven frame is on the line |

## Verification
The hardest case to reach from the ports is the threshold of the request counter. A request held for exactly six edges must not produce a training frame, while a seventh edge must. Requests that alternate between the two inputs must keep counting. The bench reaches both cases from the data sweep itself: `sync_req_a` is tied to the payload count modulo eight, which produces many back-to-back runs of exactly six. Dedicated runs then hand the request from one input to the other without a gap, and drop the power-up and drive-enable inputs in the middle of training.

// File: rtl/lft_pkg.sv
`timescale 1ns/1ps
package lft_pkg;
  typedef enum logic [1:0] {
    KIND_QUIET = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_TRAIN = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/lft_rst_sync.sv
`timescale 1ns/1ps
module lft_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/lft_word_capture.sv
`timescale 1ns/1ps
module lft_word_capture #(
  parameter int DATA_W      = 10,
  parameter int HOLD_CYCLES = 6
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_in,
  input  logic              req_a,
  input  logic              req_b,
  output logic [DATA_W-1:0] shadow,
  output logic              train_mode
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_CYCLES + 1);

  logic [DATA_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0]  run_q, run_d;

  always_comb begin
    shadow_d = word_in;
    if (req_a || req_b) begin
      if (run_q != CNT_TOP) run_d = run_q + CNT_W'(1);
      else                  run_d = run_q;
    end else begin
      run_d = '0;
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      run_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      run_q    <= run_d;
    end
  end

  assign shadow     = shadow_q;
  assign train_mode = (run_q == CNT_TOP);
endmodule

// File: rtl/lft_bit_serializer.sv
`timescale 1ns/1ps
module lft_bit_serializer
  import lft_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              wclk,
  input  logic [DATA_W-1:0] shadow,
  input  logic              train_mode,
  input  logic              pwr_up,
  input  logic              drive_en,
  output logic              ser_bit,
  output logic              ser_valid
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic               wclk_q;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic               bit_q, bit_d;
  logic               valid_q, valid_d;
  logic               load;
  frame_kind_e        kind;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] train_pat;

  genvar gi;
  generate
    for (gi = 0; gi < FRAME_W; gi++) begin : g_pat
      assign train_pat[gi] = (gi < FRAME_W / 2);
    end
  endgenerate

  assign load = wclk && !wclk_q;

  always_comb begin
    if (!(pwr_up && drive_en)) kind = KIND_QUIET;
    else if (train_mode)       kind = KIND_TRAIN;
    else                       kind = KIND_DATA;

    case (kind)
      KIND_TRAIN: frame = train_pat;
      KIND_DATA:  frame = {1'b0, shadow, 1'b1};
      default:    frame = '0;
    endcase
  end

  always_comb begin
    sr_d    = sr_q;
    left_d  = left_q;
    bit_d   = 1'b0;
    valid_d = 1'b0;
    if (load) begin
      valid_d = (kind != KIND_QUIET);
      bit_d   = frame[0];
      sr_d    = frame >> 1;
      left_d  = LAST_IDX;
    end else if (left_q != '0) begin
      valid_d = valid_q;
      bit_d   = valid_q && sr_q[0];
      sr_d    = sr_q >> 1;
      left_d  = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q  <= 1'b0;
      sr_q    <= '0;
      left_q  <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      wclk_q  <= wclk;
      sr_q    <= sr_d;
      left_q  <= left_d;
      bit_q   <= bit_d;
      valid_q <= valid_d;
    end
  end

  assign ser_bit   = bit_q;
  assign ser_valid = valid_q;
endmodule

// File: rtl/link_frame_tx.sv
`timescale 1ns/1ps
module link_frame_tx #(
  parameter int DATA_W      = 10,
  parameter int HOLD_CYCLES = 6
) (
  input  logic              bit_clk,
  input  logic              word_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  input  logic              pwr_up,
  input  logic              drive_en,
  output logic              tx_bit,
  output logic              tx_valid
);
  logic              word_rst_n;
  logic              bit_rst_n;
  logic [DATA_W-1:0] shadow;
  logic              train_mode;

  lft_rst_sync u_word_rst (
    .clk    (word_clk),
    .arst_n (rst_n),
    .srst_n (word_rst_n)
  );

  lft_rst_sync u_bit_rst (
    .clk    (bit_clk),
    .arst_n (rst_n),
    .srst_n (bit_rst_n)
  );

  lft_word_capture #(
    .DATA_W      (DATA_W),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_capture (
    .wclk       (word_clk),
    .rst_n      (word_rst_n),
    .word_in    (tx_word),
    .req_a      (sync_req_a),
    .req_b      (sync_req_b),
    .shadow     (shadow),
    .train_mode (train_mode)
  );

  lft_bit_serializer #(
    .DATA_W (DATA_W)
  ) u_serial (
    .bclk       (bit_clk),
    .rst_n      (bit_rst_n),
    .wclk       (word_clk),
    .shadow     (shadow),
    .train_mode (train_mode),
    .pwr_up     (pwr_up),
    .drive_en   (drive_en),
    .ser_bit    (tx_bit),
    .ser_valid  (tx_valid)
  );
endmodule

// File: rtl/lft_checker.sv
`timescale 1ns/1ps
module lft_checker #(
  parameter int FRAME_W = 12
) (
  input logic bclk,
  input logic rst_n,
  input logic wclk,
  input logic pwr_up,
  input logic drive_en,
  input logic tx_bit,
  input logic tx_valid
);
  localparam int PW = $clog2(FRAME_W) + 1;
  localparam logic [PW-1:0] POS_IDLE = '1;
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_W - 1);

  logic          wq;
  logic [PW-1:0] pos;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      wq  <= 1'b0;
      pos <= POS_IDLE;
    end else begin
      wq <= wclk;
      if (wclk && !wq)          pos <= '0;
      else if (pos != POS_IDLE) pos <= pos + PW'(1);
    end
  end

  a_r8_quiet_line: assert property (@(posedge bclk) disable iff (!rst_n)
    !tx_valid |-> !tx_bit);

  a_r2_start_marker: assert property (@(posedge bclk) disable iff (!rst_n)
    (wclk && !wq && pwr_up && drive_en) |=> (tx_valid && tx_bit));

  a_r2_end_marker: assert property (@(posedge bclk) disable iff (!rst_n)
    (pos == POS_LAST && tx_valid) |-> !tx_bit);

  a_r9_valid_steady: assert property (@(posedge bclk) disable iff (!rst_n)
    (pos >= PW'(1) && pos <= POS_LAST) |-> $stable(tx_valid));

  a_r7_needs_enables: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(pwr_up && drive_en));
endmodule

bind link_frame_tx lft_checker #(.FRAME_W(DATA_W + 2)) u_lft_checker (
  .bclk     (bit_clk),
  .rst_n    (bit_rst_n),
  .wclk     (word_clk),
  .pwr_up   (pwr_up),
  .drive_en (drive_en),
  .tx_bit   (tx_bit),
  .tx_valid (tx_valid)
);

// File: tb/test_link_frame_tx.sv
`timescale 1ns/1ps
module test_link_frame_tx;
  logic       bclk = 1'b0;
  logic       wclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = '0;
  logic       req_a = 1'b0, req_b = 1'b0;
  logic       pwr = 1'b0, den = 1'b0;
  logic       tx_bit, tx_valid;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  int          mcnt = 0;
  bit          armed = 0, have_exp = 0, rst_chk = 0, prev_sync = 0;
  logic [11:0] exp_bits, rx_bits, rx_val;
  logic        exp_valid;
  string       exp_tag;

  always #10 bclk = ~bclk;

  link_frame_tx i_link_frame_tx (
    .bit_clk(bclk), .word_clk(wclk), .rst_n(rst_n), .tx_word(din),
    .sync_req_a(req_a), .sync_req_b(req_b), .pwr_up(pwr), .drive_en(den),
    .tx_bit(tx_bit), .tx_valid(tx_valid)
  );

  task automatic judge_frame();
    checks++;
    if (rx_bits !== exp_bits || rx_val !== {12{exp_valid}}) begin
      fails++;
      $display("FAIL %s: bits %b valid %b, expected bits %b valid %b",
               exp_tag, rx_bits, rx_val, exp_bits, {12{exp_valid}});
    end
    checks++;
    if (rx_val !== 12'h000 && rx_val !== 12'hFFF) begin
      fails++;
      $display("FAIL R9: valid within frame %b, expected all equal", rx_val);
    end
  endtask

  task automatic run_word(input logic [9:0] d, input logic ra, input logic rb,
                          input logic aw, input logic en);
    for (int k = 0; k < 12; k++) begin
      int p;
      int idx;
      bit sync;
      p   = (6 + k) % 12;
      idx = (p + 11) % 12;
      @(negedge bclk);
      rx_bits[idx] = tx_bit;
      rx_val[idx]  = tx_valid;
      if (rst_chk) begin
        checks++;
        if (tx_bit !== 1'b0 || tx_valid !== 1'b0) begin
          fails++;
          $display("FAIL R1: bit %b valid %b, expected 0 0", tx_bit, tx_valid);
        end
      end
      if (have_exp) begin
        checks++;
        if (!tx_valid && tx_bit) begin
          fails++;
          $display("FAIL R8: bit %b valid %b, expected bit 0", tx_bit, tx_valid);
        end
      end
      if (p == 6) begin
        wclk = 1'b0; din = d; req_a = ra; req_b = rb; pwr = aw; den = en;
      end
      if (p == 0) begin
        if (have_exp) judge_frame();
        wclk = 1'b1;
        if (req_a || req_b) mcnt = (mcnt < 7) ? mcnt + 1 : 7;
        else                mcnt = 0;
        sync = (mcnt > 6);
        if (!(pwr && den)) begin
          exp_valid = 1'b0; exp_bits = '0; exp_tag = "R7";
        end else if (sync) begin
          exp_valid = 1'b1; exp_bits = 12'b000000111111; exp_tag = "R4";
        end else begin
          exp_valid = 1'b1; exp_bits = {1'b0, din, 1'b1};
          if (prev_sync)      exp_tag = "R6";
          else if (mcnt == 6) exp_tag = "R5";
          else                exp_tag = "R2 R3";
        end
        prev_sync = sync;
        have_exp  = armed;
      end
    end
  endtask

  initial begin
    rst_chk = 1;
    for (int i = 0; i < 3; i++) run_word(10'h3FF, 1'b1, 1'b1, 1'b1, 1'b1);
    rst_chk = 0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) run_word(10'h000, 1'b0, 1'b0, 1'b0, 1'b0);
    mcnt = 0;
    armed = 1;
    // full payload sweep; request A runs of exactly six (R5)
    for (int w = 0; w < 1024; w++) run_word(10'(w), (w % 8) < 6, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) run_word(10'h2AA, 1'b0, 1'b0, 1'b1, 1'b1);
    // request A held ten words, then released (R4, R6)
    for (int i = 0; i < 10; i++) run_word(10'h155 ^ 10'(i), 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) run_word(10'h0F0 + 10'(i), 1'b0, 1'b0, 1'b1, 1'b1);
    // request B held seven words (R4 threshold)
    for (int i = 0; i < 7; i++) run_word(10'h301 + 10'(i), 1'b0, 1'b1, 1'b1, 1'b1);
    run_word(10'h001, 1'b0, 1'b0, 1'b1, 1'b1);
    // hand-over from A to B keeps counting (R4)
    for (int i = 0; i < 4; i++) run_word(10'h0AA, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) run_word(10'h055, 1'b0, 1'b1, 1'b1, 1'b1);
    run_word(10'h3C3, 1'b0, 1'b0, 1'b1, 1'b1);
    // gating during training and data (R7)
    for (int i = 0; i < 12; i++)
      run_word(10'h111 * 10'(i), 1'b1, 1'b1, !(i == 8 || i == 9), i != 10);
    run_word(10'h222, 1'b0, 1'b0, 1'b1, 1'b0);
    run_word(10'h333, 1'b0, 1'b0, 1'b0, 1'b1);
    run_word(10'h0FF, 1'b0, 1'b0, 1'b0, 1'b0);
    run_word(10'h3F0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_word(10'h000, 1'b0, 1'b0, 1'b1, 1'b1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #3ms;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule